// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Receiver

This block watches a demodulated infrared line and measures each symbol as two widths: a low phase followed by a high phase. Widths are counted in prescaler ticks. Each finished symbol is packed into one 32-bit word and pushed into a 16-entry FIFO. Software first reads a symbol count and then reads the data register that many times, each read taking one word. A high phase whose width, added to the low width before it, reaches a configured maximum marks the end of a stream. That closing symbol is still stored, but it raises a timeout event in place of a received event.

Three event flags (received, timeout, overflow) are sticky. Each is cleared by writing one to its bit, and each can be masked from the single interrupt output. The register bus is a plain single-cycle port: a write takes effect on the clock edge where `bus_wr` is high, and read data is valid combinationally in the cycle `bus_rd` is high. The data-register pop happens on that edge.

Inside the block, the measurer presents each symbol to the FIFO as a valid/ready transfer. The line cannot be stalled, so no back-pressure reaches the input. A symbol offered while the FIFO is full and not being popped is dropped and flagged as overflow, and the words already stored are kept.

Top module: `ir_capture`

## Requirements
- R1: After reset, enable (0x00) reads 0, config (0x04) reads 0x3E80_0080, busy (0x1C), count (0x20) and status (0x2C) read 0, and `irq` is low.
- R2: Writing 1 to enable bit 0 while it is 0 makes busy (0x1C) read 1 for exactly 8 cycles after the write edge, and 0 after that.
- R3: Symbols are captured only after a write to start (0x34) while enabled and no longer busy. Before that, line activity leaves the count at 0.
- R4: A stored word holds the low-phase width in [15:0] and the high-phase width in [31:16], both counted in ticks. One tick lasts (config[6:0] + 1) clocks.
- R5: Let config[31:16] be the maximum width. When low plus high width reaches it during a high phase, the word is stored with high = maximum − low (at least 1), timeout status is set, and capture waits for the next low level.
- R6: Each width counter saturates at 0xFFFF.
- R7: Count (0x20) returns the number of stored words. Each read of data (0x24) returns the oldest word and removes it. A read while empty returns 0 and changes nothing.
- R8: Received status is set when a normal symbol is stored and the count then is at least config[13:8] + 1. A timeout symbol does not set it.
- R9: With 16 words stored, a further symbol that is not matched by a pop is dropped, overflow status is set, and the stored words are kept in order.
- R10: Status (0x2C) holds raw received/timeout/overflow flags in bits 8/9/10 and the unmasked copies in bits 24/25/26. Mask (0x28) bits 0/1/2 set to 1 mask the matching source. `irq` is high while any unmasked flag is set.
- R11: Writing clear (0x30) bits 16/17/18 clears received/timeout/overflow. A flag being set in the same cycle stays set.
- R12: A push and a pop on the same edge leave the count unchanged and return the older word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on data address) |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| ir_in | input | 1 | Demodulated infrared line, idle high |
| irq | output | 1 | Interrupt, any unmasked flag set |

## Verification
Two pairs of events can land on the same edge: a symbol push with a software clear of the flag that push sets, and a symbol push with a data-register pop. The bench counts the line change through the two-flop synchronizer and issues the clear write, or the data read, so that it hits the very edge on which the symbol is stored. It then expects the received flag to stay set in the first case. In the second case it expects the count to stay where it was and the popped word to be the older one.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;
  localparam logic [5:0] A_ENABLE = 6'h00;
  localparam logic [5:0] A_CONFIG = 6'h04;
  localparam logic [5:0] A_BUSY   = 6'h1C;
  localparam logic [5:0] A_COUNT  = 6'h20;
  localparam logic [5:0] A_DATA   = 6'h24;
  localparam logic [5:0] A_MASK   = 6'h28;
  localparam logic [5:0] A_STATUS = 6'h2C;
  localparam logic [5:0] A_CLEAR  = 6'h30;
  localparam logic [5:0] A_START  = 6'h34;

  localparam logic [31:0] CFG_RESET = 32'h3E80_0080;
  localparam int unsigned CFG_MAXW_LSB  = 16;
  localparam int unsigned CFG_LEVEL_LSB = 8;
  localparam int unsigned CFG_PRE_LSB   = 0;

  localparam int unsigned NSRC = 3;
  localparam int unsigned SRC_RCV = 0;
  localparam int unsigned SRC_TMO = 1;
  localparam int unsigned SRC_OVF = 2;
  localparam int unsigned ST_RAW_LSB = 8;
  localparam int unsigned ST_UNM_LSB = 24;
  localparam int unsigned CLR_LSB    = 16;
  localparam int unsigned HIGH_LSB   = 16;

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;
endpackage

// File: rtl/ir_sync.sv
module ir_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int unsigned PRE_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q;

  assign tick = (cnt_q >= pre);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (hold) cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + PRE_W'(1);
  end
endmodule

// File: rtl/ir_width_meas.sv
module ir_width_meas #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          line,
  input  logic          tick,
  input  logic [CW-1:0] max_w,
  output logic          sym_valid,
  output logic          sym_timeout,
  output logic [CW-1:0] sym_low,
  output logic [CW-1:0] sym_high
);
  import ir_cap_pkg::*;

  localparam logic [CW-1:0] CMAX = '1;

  phase_e        st_q, st_d;
  logic [CW-1:0] low_q, low_d, high_q, high_d;
  logic [CW-1:0] low_inc, high_inc, high_nx, tick_w;
  logic [CW:0]   sum;
  logic          limit;

  always_comb begin
    tick_w   = CW'(tick);
    low_inc  = (low_q  == CMAX) ? low_q  : low_q  + tick_w;
    high_inc = (high_q == CMAX) ? high_q : high_q + tick_w;
    high_nx  = (st_q == PH_HIGH) ? high_inc : tick_w;
    sum      = {1'b0, low_q} + {1'b0, high_nx};
    limit    = (sum >= {1'b0, max_w});
  end

  always_comb begin
    st_d        = st_q;
    low_d       = low_q;
    high_d      = high_q;
    sym_valid   = 1'b0;
    sym_timeout = 1'b0;
    sym_low     = low_q;
    sym_high    = high_q;
    if (!run) begin
      st_d   = PH_IDLE;
      low_d  = '0;
      high_d = '0;
    end else begin
      case (st_q)
        PH_IDLE: begin
          if (!line) begin
            st_d   = PH_LOW;
            low_d  = tick_w;
            high_d = '0;
          end
        end
        PH_LOW, PH_HIGH: begin
          if (!line) begin
            if (st_q == PH_HIGH) begin
              sym_valid = 1'b1;
              st_d      = PH_LOW;
              low_d     = tick_w;
              high_d    = '0;
            end else begin
              low_d = low_inc;
            end
          end else if (limit) begin
            sym_valid   = 1'b1;
            sym_timeout = 1'b1;
            sym_high    = high_nx;
            st_d        = PH_IDLE;
            low_d       = '0;
            high_d      = '0;
          end else begin
            st_d   = PH_HIGH;
            high_d = high_nx;
          end
        end
        default: st_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PH_IDLE;
      low_q  <= '0;
      high_q <= '0;
    end else begin
      st_q   <= st_d;
      low_q  <= low_d;
      high_q <= high_d;
    end
  end
endmodule

// File: rtl/ir_sym_fifo.sv
module ir_sym_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [W-1:0]                 in_data,
  input  logic                         pop,
  output logic [W-1:0]                 out_data,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          full, empty, do_pop, do_push;

  assign full     = (cnt_q == CW'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign do_pop   = pop && !empty;
  assign in_ready = !full || do_pop;
  assign do_push  = in_valid && in_ready;
  assign out_data = empty ? '0 : mem[rp_q];
  assign count    = cnt_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == LAST) ? '0 : wp_q + AW'(1);
      if (do_pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + AW'(1);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/ir_irq_ctrl.sv
module ir_irq_ctrl #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] flags,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end
  end

  assign irq = |(flags & ~mask);
endmodule

// File: rtl/ir_capture.sv
module ir_capture #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned FIFO_DEPTH  = 16,
  parameter int unsigned BUSY_CYCLES = 8,
  parameter int unsigned LEVEL_W     = 6,
  parameter int unsigned PRE_W       = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        ir_in,
  output logic        irq
);
  import ir_cap_pkg::*;

  localparam int unsigned WORD_W = 2 * CNT_W;
  localparam int unsigned FCNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned BCNT_W = $clog2(BUSY_CYCLES + 1);

  logic              en_q, run_q;
  logic [31:0]       cfg_q;
  logic [NSRC-1:0]   mask_q;
  logic [BCNT_W-1:0] busy_q, busy_d;
  logic              busy, capture;
  logic              en_wr, cfg_wr, mask_wr, start_wr, clr_wr, data_rd;

  logic              line_s, tick;
  logic [CNT_W-1:0]  max_w;
  logic [LEVEL_W-1:0] level;
  logic [PRE_W-1:0]  pre;

  logic              sym_valid, sym_timeout, sym_accept;
  logic [CNT_W-1:0]  sym_low, sym_high;
  logic [WORD_W-1:0] fifo_out;
  logic [FCNT_W-1:0] fifo_cnt, cnt_after;
  logic              fifo_pop;

  logic [NSRC-1:0]   src_set, src_clr, flags;
  logic [31:0]       status_w, data_w;

  assign en_wr    = bus_wr && (bus_addr == A_ENABLE);
  assign cfg_wr   = bus_wr && (bus_addr == A_CONFIG);
  assign mask_wr  = bus_wr && (bus_addr == A_MASK);
  assign start_wr = bus_wr && (bus_addr == A_START);
  assign clr_wr   = bus_wr && (bus_addr == A_CLEAR);
  assign data_rd  = bus_rd && (bus_addr == A_DATA);

  assign max_w = cfg_q[CFG_MAXW_LSB +: CNT_W];
  assign level = cfg_q[CFG_LEVEL_LSB +: LEVEL_W];
  assign pre   = cfg_q[CFG_PRE_LSB +: PRE_W];

  assign busy    = (busy_q != '0);
  assign capture = en_q && run_q && !busy;

  always_comb begin
    busy_d = busy ? busy_q - BCNT_W'(1) : busy_q;
    if (en_wr && bus_wdata[0] && !en_q) busy_d = BCNT_W'(BUSY_CYCLES);
    if (en_wr && !bus_wdata[0])         busy_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      run_q  <= 1'b0;
      cfg_q  <= CFG_RESET;
      mask_q <= '0;
      busy_q <= '0;
    end else begin
      busy_q <= busy_d;
      if (en_wr)   en_q   <= bus_wdata[0];
      if (cfg_wr)  cfg_q  <= bus_wdata;
      if (mask_wr) mask_q <= bus_wdata[NSRC-1:0];
      if (en_wr && !bus_wdata[0]) run_q <= 1'b0;
      else if (start_wr && en_q)  run_q <= 1'b1;
    end
  end

  ir_sync #(.STAGES(2)) u_sync (
    .clk (clk), .rst_n (rst_n), .d (ir_in), .q (line_s)
  );

  ir_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk (clk), .rst_n (rst_n), .hold (!capture), .pre (pre), .tick (tick)
  );

  ir_width_meas #(.CW(CNT_W)) u_meas (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (capture),
    .line        (line_s),
    .tick        (tick),
    .max_w       (max_w),
    .sym_valid   (sym_valid),
    .sym_timeout (sym_timeout),
    .sym_low     (sym_low),
    .sym_high    (sym_high)
  );

  assign fifo_pop = data_rd && (fifo_cnt != '0);

  ir_sym_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (sym_valid),
    .in_ready (sym_accept),
    .in_data  ({sym_high, sym_low}),
    .pop      (fifo_pop),
    .out_data (fifo_out),
    .count    (fifo_cnt)
  );

  assign cnt_after = fifo_pop ? fifo_cnt : fifo_cnt + FCNT_W'(1);

  always_comb begin
    src_set          = '0;
    src_set[SRC_RCV] = sym_valid && sym_accept && !sym_timeout &&
                       (32'(cnt_after) >= 32'(level) + 32'd1);
    src_set[SRC_TMO] = sym_valid && sym_accept && sym_timeout;
    src_set[SRC_OVF] = sym_valid && !sym_accept;
    src_clr          = clr_wr ? bus_wdata[CLR_LSB +: NSRC] : '0;
  end

  ir_irq_ctrl #(.N(NSRC)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (src_set),
    .clr   (src_clr),
    .mask  (mask_q),
    .flags (flags),
    .irq   (irq)
  );

  always_comb begin
    status_w = '0;
    status_w[ST_RAW_LSB +: NSRC] = flags;
    status_w[ST_UNM_LSB +: NSRC] = flags & ~mask_q;
    data_w = '0;
    data_w[0 +: CNT_W]        = fifo_out[0 +: CNT_W];
    data_w[HIGH_LSB +: CNT_W] = fifo_out[CNT_W +: CNT_W];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_ENABLE: bus_rdata = {31'd0, en_q};
        A_CONFIG: bus_rdata = cfg_q;
        A_BUSY:   bus_rdata = {31'd0, busy};
        A_COUNT:  bus_rdata = 32'(fifo_cnt);
        A_DATA:   bus_rdata = data_w;
        A_MASK:   bus_rdata = 32'(mask_q);
        A_STATUS: bus_rdata = status_w;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ir_capture_chk.sv
module ir_capture_chk #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned FCNT_W     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_wr,
  input logic              clr_wr,
  input logic              data_rd,
  input logic [31:0]       bus_wdata,
  input logic              en_q,
  input logic              busy,
  input logic              capture,
  input logic              sym_valid,
  input logic              sym_timeout,
  input logic              sym_accept,
  input logic [CNT_W-1:0]  sym_low,
  input logic [CNT_W-1:0]  sym_high,
  input logic [CNT_W-1:0]  max_w,
  input logic [FCNT_W-1:0] fifo_cnt,
  input logic [2:0]        src_set,
  input logic [2:0]        flags
);
  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fifo_cnt) <= FIFO_DEPTH);  // R9
  AST_POP_TAKES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && fifo_cnt != '0 && !(sym_valid && sym_accept)) |=> fifo_cnt == $past(fifo_cnt) - FCNT_W'(1));  // R7
  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && fifo_cnt != '0 && sym_valid && sym_accept) |=> fifo_cnt == $past(fifo_cnt));  // R12
  AST_TIMEOUT_REACH: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_timeout) |-> ({1'b0, sym_low} + {1'b0, sym_high}) >= {1'b0, max_w});  // R5
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |-> !sym_valid);  // R3
  AST_DROP_FLAGS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !sym_accept) |=> flags[2]);  // R9
  AST_CLEAR_RCV: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && bus_wdata[16] && !src_set[0]) |=> !flags[0]);  // R11
  AST_BUSY_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && bus_wdata[0] && !en_q) |=> busy);  // R2
endmodule

bind ir_capture ir_capture_chk #(
  .CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH), .FCNT_W(FCNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_wr       (en_wr),
  .clr_wr      (clr_wr),
  .data_rd     (data_rd),
  .bus_wdata   (bus_wdata),
  .en_q        (en_q),
  .busy        (busy),
  .capture     (capture),
  .sym_valid   (sym_valid),
  .sym_timeout (sym_timeout),
  .sym_accept  (sym_accept),
  .sym_low     (sym_low),
  .sym_high    (sym_high),
  .max_w       (max_w),
  .fifo_cnt    (fifo_cnt),
  .src_set     (src_set),
  .flags       (flags)
);

// File: tb/ir_capture_tb.sv
module ir_capture_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ir_in = 1'b1;
  logic        irq;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  ir_capture u_dut (
    .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_rd (bus_rd),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .ir_in (ir_in), .irq (irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sym(input int lo, input int hi);
    ir_in = 1'b0; cyc(lo);
    ir_in = 1'b1; cyc(hi);
  endtask

  task automatic term(input int lo, input int wait_n);
    ir_in = 1'b0; cyc(lo);
    ir_in = 1'b1; cyc(wait_n);
  endtask

  function automatic logic [31:0] cfgw(input int maxw, input int lvl, input int pre);
    return {maxw[15:0], 2'b00, lvl[5:0], 1'b1, pre[6:0]};
  endfunction

  function automatic logic [31:0] word(input int lo, input int hi);
    return {hi[15:0], lo[15:0]};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    rd(6'h00, v); check("R1 enable", v, 32'h0);
    rd(6'h04, v); check("R1 config", v, 32'h3E80_0080);
    rd(6'h1C, v); check("R1 busy", v, 32'h0);
    rd(6'h20, v); check("R1 count", v, 32'h0);
    rd(6'h2C, v); check("R1 status", v, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);

    // R3 nothing captured while disabled
    wr(6'h04, cfgw(40, 0, 0));
    sym(3, 3); term(1, 50);
    rd(6'h20, v); check("R3 count while disabled", v, 32'h0);

    // R2 busy window
    wr(6'h00, 32'h1);
    cyc(7);
    rd(6'h1C, v); check("R2 busy at cycle 8", v, 32'h1);
    rd(6'h1C, v); check("R2 busy after window", v, 32'h0);

    // R3 enabled but not started
    sym(3, 3); term(1, 50);
    rd(6'h20, v); check("R3 count before start", v, 32'h0);
    wr(6'h34, 32'h1);

    // R4 R5 R7 R8 sweep over low/high widths
    for (int lo = 1; lo <= 8; lo++) begin
      for (int hi = 1; hi <= 6; hi++) sym(lo, hi);
      term(1, 50);
      rd(6'h20, v); check("R7 count after batch", v, 32'd7);
      rd(6'h2C, v); check("R5 R8 status after batch", v, 32'h0300_0300);
      for (int hi = 1; hi <= 6; hi++) begin
        rd(6'h24, v); check("R4 symbol word", v, word(lo, hi));
      end
      rd(6'h24, v); check("R5 timeout word", v, word(1, 39));
      wr(6'h30, 32'h0007_0000);
    end
    rd(6'h24, v); check("R7 empty read", v, 32'h0);
    rd(6'h20, v); check("R7 count stays 0", v, 32'h0);

    // R4 prescale: 4 clocks per tick
    wr(6'h04, cfgw(20, 0, 3));
    sym(40, 24); term(4, 100);
    rd(6'h24, v); check("R4 prescaled word", v, word(10, 6));
    rd(6'h24, v); check("R4 prescaled timeout", v, word(1, 19));

    // R6 saturation with max width 0xFFFF
    wr(6'h04, cfgw(16'hFFFF, 0, 0));
    wr(6'h30, 32'h0007_0000);
    term(70000, 10);
    rd(6'h20, v); check("R6 count", v, 32'd1);
    rd(6'h24, v); check("R6 saturated word", v, 32'h0001_FFFF);
    rd(6'h2C, v); check("R6 R5 timeout flag", v, 32'h0200_0200);
    wr(6'h30, 32'h0007_0000);

    // R8 interrupt level 2 -> needs 3 words
    wr(6'h04, cfgw(40, 2, 0));
    sym(3, 3); sym(3, 3);
    ir_in = 1'b0; cyc(5);
    rd(6'h20, v); check("R8 count 2", v, 32'd2);
    rd(6'h2C, v); check("R8 no rcv below level", v, 32'h0);
    ir_in = 1'b1; cyc(3);
    ir_in = 1'b0; cyc(5);
    rd(6'h2C, v); check("R8 rcv at level", v, 32'h0100_0100);
    ir_in = 1'b1; cyc(50);
    for (int k = 0; k < 4; k++) rd(6'h24, v);
    wr(6'h30, 32'h0007_0000);

    // R10 R11 masking and clearing
    wr(6'h04, cfgw(40, 0, 0));
    wr(6'h28, 32'h3);
    sym(2, 2); term(1, 50);
    rd(6'h2C, v); check("R10 masked status", v, 32'h0000_0300);
    check("R10 irq masked", {31'd0, irq}, 32'h0);
    wr(6'h28, 32'h0);
    rd(6'h2C, v); check("R10 unmasked status", v, 32'h0300_0300);
    check("R10 irq unmasked", {31'd0, irq}, 32'h1);
    wr(6'h30, 32'h0001_0000);
    rd(6'h2C, v); check("R11 clear rcv only", v, 32'h0200_0200);
    wr(6'h30, 32'h0002_0000);
    rd(6'h2C, v); check("R11 clear timeout", v, 32'h0);
    check("R11 irq low", {31'd0, irq}, 32'h0);
    rd(6'h24, v); rd(6'h24, v);

    // R9 overflow keeps contents
    for (int k = 0; k < 18; k++) sym(2, k + 1);
    term(1, 50);
    rd(6'h20, v); check("R9 count full", v, 32'd16);
    rd(6'h2C, v); check("R9 status", v, 32'h0500_0500);
    for (int k = 0; k < 16; k++) begin
      rd(6'h24, v); check("R9 kept word", v, word(2, k + 1));
    end
    rd(6'h20, v); check("R9 drained", v, 32'h0);
    wr(6'h30, 32'h0007_0000);
    rd(6'h2C, v); check("R11 all cleared", v, 32'h0);

    // R11 clear on the push edge: set wins
    sym(2, 2);
    ir_in = 1'b0; cyc(2);
    wr(6'h30, 32'h0001_0000);
    rd(6'h2C, v); check("R11 set beats clear", v, 32'h0100_0100);
    cyc(2);
    ir_in = 1'b1; cyc(50);
    rd(6'h24, v); rd(6'h24, v);
    wr(6'h30, 32'h0007_0000);

    // R12 pop on the push edge
    sym(2, 2);
    ir_in = 1'b0; cyc(3);
    ir_in = 1'b1; cyc(2);
    ir_in = 1'b0; cyc(2);
    rd(6'h24, v); check("R12 older word popped", v, word(2, 2));
    rd(6'h20, v); check("R12 count unchanged", v, 32'd1);
    ir_in = 1'b1; cyc(50);
    rd(6'h24, v); check("R12 second word", v, word(3, 2));
    rd(6'h24, v); check("R12 closing word", v, word(4, 36));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule